// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block turns one fast source clock into three banks of four divided clocks and one feedback clock. Bank A, bank B and bank C each take a two-bit ratio select. The feedback path takes a three-bit select. One range input is shared by all four paths. When the range input is high, every ratio is half the value it has when the range input is low. Every ratio is even. Each output is therefore high for half of its period and low for the other half.

A phase input shifts the two upper lanes of bank C by half a period. An active-low master reset clears all dividers and holds every output low. It also drops an enable output, which tells the pad drivers to release the lines. On the first source edge after release, every path starts a new period with a rising edge, so the rising edges of all paths stay coincident. A ratio select is taken in only at the end of a full output period. A select change therefore never creates a short pulse. Every select is plain control, so no input or output uses a handshake.

Top module: `clk_bank_divider`

## Requirements
- R1: Bank A divides the source by 8, 12, 16 or 24 for `sel_a` codes 0, 1, 2 and 3 when `range_hi` is 0. It divides by 4, 6, 8 or 12 when `range_hi` is 1. All four lanes of `q_a` are identical.
- R2: Bank B divides by 8, 12, 16 or 20 for `sel_b` codes 0 to 3 when `range_hi` is 0. It divides by 4, 6, 8 or 10 when `range_hi` is 1.
- R3: Bank C lanes 0 and 1 divide by 4, 8, 12 or 16 for `sel_c` codes 0 to 3 when `range_hi` is 0. They divide by 2, 4, 6 or 8 when `range_hi` is 1.
- R4: `q_fb` uses the 3-bit code `sel_fb`, whose MSB is bit 2. With `range_hi` 0, codes 0 to 7 give 8, 12, 16, 20, 16, 24, 32 and 40. With `range_hi` 1, they give 4, 6, 8, 10, 8, 12, 16 and 20.
- R5: When `inv_c` is 1, `q_c[3:2]` carry the complement of `q_c[1:0]`. When `inv_c` is 0, all four bank C lanes are equal. This input takes effect at once.
- R6: While `rst_n` is low, every clock output and `q_en` is 0 from the first source edge on.
- R7: On the first source edge with `rst_n` high, `q_en` goes to 1 and every non-inverted output rises. After that, each path starts a new period every divisor edges, counted from that edge.
- R8: A select or `range_hi` change takes effect only at the edge that begins a new period of that path. The period in progress completes with its old length.
- R9: Each output is high for divisor/2 source cycles and then low for divisor/2 source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low master reset and output disable |
| range_hi | input | 1 | 1 selects the halved divisor set |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code, bit 2 is the MSB |
| inv_c | input | 1 | Inverts bank C lanes 2 and 3 |
| q_a | output | 4 | Bank A clocks |
| q_b | output | 4 | Bank B clocks |
| q_c | output | 4 | Bank C clocks |
| q_fb | output | 1 | Feedback clock |
| q_en | output | 1 | Output driver enable, low during reset |

## Verification
A behavioural reference tracks each path's position within its period. It is compared with every output on every clock.

- **Ratio sweep.** The bench steps through all eight codes under both range settings. A wrong table entry, or a range bit that is ignored, shows up as a period of the wrong length.
- **Mid-period select changes.** The bench changes the selects every few cycles. This separates sampling at the period end from sampling at once: the latter cuts periods short.
- **Toggling the phase input.** This checks that only the two upper bank C lanes follow it.
- **Reset in mid-run, then release.** This exercises the gating during reset and the common restart of all paths.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int HALF_W = 5;
  localparam int PH_W   = HALF_W + 1;
  localparam int NPATH  = 4;
  localparam int BANK_LANES = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {PATH_A, PATH_B, PATH_C, PATH_FB} path_t;
  typedef logic [HALF_W-1:0] half_t;

  // half-period length in source cycles for the fast (halved) set
  function automatic half_t fast_half(path_t p, logic [SEL_W-1:0] s);
    half_t h;
    case (p)
      PATH_A: case (s[1:0])
        2'd0: h = 5'd2;
        2'd1: h = 5'd3;
        2'd2: h = 5'd4;
        default: h = 5'd6;
      endcase
      PATH_B: case (s[1:0])
        2'd0: h = 5'd2;
        2'd1: h = 5'd3;
        2'd2: h = 5'd4;
        default: h = 5'd5;
      endcase
      PATH_C: case (s[1:0])
        2'd0: h = 5'd1;
        2'd1: h = 5'd2;
        2'd2: h = 5'd3;
        default: h = 5'd4;
      endcase
      default: begin
        case (s[1:0])
          2'd0: h = 5'd2;
          2'd1: h = 5'd3;
          2'd2: h = 5'd4;
          default: h = 5'd5;
        endcase
        if (s[2]) h = h << 1;
      end
    endcase
    return h;
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter path_t PATH = PATH_A
) (
  input  logic             range_hi,
  input  logic [SEL_W-1:0] sel,
  output half_t            half
);
  half_t base;
  always_comb begin
    base = fast_half(PATH, sel);
    half = range_hi ? base : half_t'(base << 1);
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  half_t half_in,
  output logic  tick
);
  half_t           half_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] mid_ph;

  assign last_ph = {half_q, 1'b0} - PH_W'(1);
  assign mid_ph  = {1'b0, half_q} - PH_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= half_in;
      ph_q   <= {half_in, 1'b0} - PH_W'(1);
      tick   <= 1'b0;
    end else if (ph_q == last_ph) begin
      ph_q   <= '0;
      tick   <= 1'b1;
      half_q <= half_in;
    end else begin
      ph_q <= ph_q + PH_W'(1);
      if (ph_q == mid_ph) tick <= 1'b0;
    end
  end

  // R8: ratio is only taken in at a period boundary
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != last_ph) |=> $stable(half_q));

  // R9: phase never leaves the current period
  a_r9_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < {half_q, 1'b0});
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int LANES    = 4,
  parameter int INV_FROM = 4
) (
  input  logic             running,
  input  logic             base,
  input  logic             inv,
  output logic [LANES-1:0] lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit INV_LANE = (i >= INV_FROM);
    assign lanes[i] = running & (base ^ (inv & INV_LANE));
  end
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       range_hi,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  input  logic [1:0] sel_c,
  input  logic [2:0] sel_fb,
  input  logic       inv_c,
  output logic [3:0] q_a,
  output logic [3:0] q_b,
  output logic [3:0] q_c,
  output logic       q_fb,
  output logic       q_en
);
  localparam int C_INV_FROM = BANK_LANES / 2;

  logic [SEL_W-1:0] sel_w  [NPATH];
  half_t            half_w [NPATH];
  logic [NPATH-1:0] base_w;
  logic             running;

  assign sel_w[0] = {1'b0, sel_a};
  assign sel_w[1] = {1'b0, sel_b};
  assign sel_w[2] = {1'b0, sel_c};
  assign sel_w[3] = sel_fb;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    clkdiv_decode #(.PATH(path_t'(p))) u_dec (
      .range_hi (range_hi),
      .sel      (sel_w[p]),
      .half     (half_w[p])
    );
    clkdiv_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .half_in (half_w[p]),
      .tick    (base_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b0;
    else        running <= 1'b1;
  end
  assign q_en = running;

  clkdiv_fanout #(.LANES(BANK_LANES), .INV_FROM(BANK_LANES)) u_fan_a (
    .running (running), .base (base_w[0]), .inv (1'b0), .lanes (q_a));
  clkdiv_fanout #(.LANES(BANK_LANES), .INV_FROM(BANK_LANES)) u_fan_b (
    .running (running), .base (base_w[1]), .inv (1'b0), .lanes (q_b));
  clkdiv_fanout #(.LANES(BANK_LANES), .INV_FROM(C_INV_FROM)) u_fan_c (
    .running (running), .base (base_w[2]), .inv (inv_c), .lanes (q_c));
  clkdiv_fanout #(.LANES(1), .INV_FROM(1)) u_fan_fb (
    .running (running), .base (base_w[3]), .inv (1'b0), .lanes (q_fb));

  // R6: quiet outputs while held in reset
  a_r6_quiet_in_reset: assert property (@(posedge clk) disable iff (rst_n)
    !rst_n |=> (q_a == 4'd0 && q_b == 4'd0 && q_c == 4'd0 && !q_fb && !q_en));

  // R7: every path starts high together on release
  a_r7_common_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_en) |-> (&q_a && &q_b && &q_c[1:0] && q_fb));

  // R5: upper bank C lanes follow the phase control
  a_r5_upper_phase: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |-> (q_c[2] == (q_c[0] ^ inv_c)) && (q_c[3] == q_c[2]));
endmodule

// File: tb/clk_bank_divider_test.sv
module clk_bank_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic range_hi = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic [2:0] sel_fb = 3'd0;
  logic inv_c = 1'b0;
  logic [3:0] q_a, q_b, q_c;
  logic q_fb, q_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase_tag = "R6";

  always #10 clk = ~clk;

  clk_bank_divider uut (
    .clk(clk), .rst_n(rst_n), .range_hi(range_hi),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
    .inv_c(inv_c), .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_fb(q_fb), .q_en(q_en)
  );

  // divisor tables as stated in R1..R4
  function automatic int div_of(int p, bit r, int s);
    int d;
    case (p)
      0: d = (s == 0) ? 8 : (s == 1) ? 12 : (s == 2) ? 16 : 24;
      1: d = (s == 0) ? 8 : (s == 1) ? 12 : (s == 2) ? 16 : 20;
      2: d = (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 12 : 16;
      default: begin
        d = ((s & 3) == 0) ? 8 : ((s & 3) == 1) ? 12 : ((s & 3) == 2) ? 16 : 20;
        if (s >= 4) d = d * 2;
      end
    endcase
    return r ? d / 2 : d;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, phase_tag, $time, act, exp);
    end
  endtask

  // reference: position inside current period per path
  int  pos [4];
  int  len [4];
  bit  run_m = 1'b0;
  bit  lvl [4];

  always @(posedge clk) begin
    int sv [4];
    sv[0] = sel_a; sv[1] = sel_b; sv[2] = sel_c; sv[3] = sel_fb;
    if (!rst_n) begin
      run_m = 1'b0;
      for (int p = 0; p < 4; p++) pos[p] = -1;
    end else begin
      run_m = 1'b1;
      for (int p = 0; p < 4; p++) begin
        if (pos[p] < 0 || pos[p] == len[p] - 1) begin
          pos[p] = 0;
          len[p] = div_of(p, range_hi, sv[p]);
        end else pos[p]++;
      end
    end
    for (int p = 0; p < 4; p++) lvl[p] = run_m && pos[p] >= 0 && pos[p] < len[p] / 2;
    #5;
    if (!run_m) begin
      check(q_a == 0 && q_b == 0 && q_c == 0 && !q_fb && !q_en, "R6",
            {q_en, q_fb, q_c, q_b, q_a}, 0);
    end else begin
      check(q_en, "R7", q_en, 1);
      check(q_a == {4{lvl[0]}}, "R1", q_a, {4{lvl[0]}});
      check(q_b == {4{lvl[1]}}, "R2", q_b, {4{lvl[1]}});
      check(q_c[1:0] == {2{lvl[2]}}, "R3", q_c[1:0], {2{lvl[2]}});
      check(q_c[3:2] == {2{lvl[2] ^ inv_c}}, "R5", q_c[3:2], {2{lvl[2] ^ inv_c}});
      check(q_fb == lvl[3], "R4", q_fb, lvl[3]);
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait_cycles(4);
    // R7: common start after release, then steady ratios (R9 duty)
    phase_tag = "R7";
    rst_n = 1'b1;
    @(posedge clk); #5;
    check(&q_a && &q_b && &q_c[1:0] && q_fb, "R7", {q_fb, q_c, q_b, q_a}, 13'h1fff);
    wait_cycles(200);
    // R1..R4 sweep over codes and both ranges
    for (int r = 0; r < 2; r++) begin
      for (int code = 0; code < 8; code++) begin
        phase_tag = "R9";
        range_hi = r[0];
        sel_a = code[1:0]; sel_b = code[1:0]; sel_c = code[1:0]; sel_fb = code[2:0];
        wait_cycles(100);
      end
    end
    // R5: phase control toggling
    phase_tag = "R5";
    inv_c = 1'b1; wait_cycles(60);
    inv_c = 1'b0; wait_cycles(30);
    inv_c = 1'b1; wait_cycles(30);
    // R8: select changes inside periods
    phase_tag = "R8";
    for (int k = 0; k < 60; k++) begin
      sel_a = 2'(k); sel_b = 2'(k + 1); sel_c = 2'(k * 3); sel_fb = 3'(k * 5);
      range_hi = k[2];
      wait_cycles(7);
    end
    // R6: reset mid-run, then R7 realignment
    phase_tag = "R6";
    rst_n = 1'b0; wait_cycles(10);
    phase_tag = "R7";
    sel_a = 2'd3; sel_b = 2'd3; sel_c = 2'd0; sel_fb = 3'd7; range_hi = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #5;
    check(&q_a && &q_b && &q_c[1:0] && q_fb, "R7", {q_fb, q_c, q_b, q_a}, 13'h1fff);
    wait_cycles(250);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (%s) actual=%0d expected=%0d", phase_tag, 0, 1);
      finish_run();
    end
  end
endmodule